// File: doc/BRIEF.md
# Byte-Serial Status Packet Generator

This block reports a status word to a shared upstream channel that carries one byte per clock. When a report is due it raises a request and holds it. The channel grants it by pulsing an acknowledge. The byte taken with that acknowledge is a fixed identification byte. The payload bytes follow on consecutive clocks, and all of them come from one snapshot of the status taken at the acknowledge.

An 8-bit control value is loaded through a one-cycle write strobe. Its two low bits choose how reports are triggered: none, a single report, or a report after every change of the status. Its upper six bits carry a sequence tag, which is placed in the first payload byte next to the two lowest status bits. Software can use that tag to match a report to the request that caused it. A payload-width parameter sets how many payload bytes a packet has.

Top module: `stat_pkt_gen`

## Requirements
- R1: After reset, `pkt_req` is low, `pkt_byte` is 0x00 and the reporting mode is off, so status changes raise no request.
- R2: A write of `ctrl_wd[1:0]` = 01 (single report) while idle raises `pkt_req` at the rising edge after the edge that samples `ctrl_we`.
- R3: Once raised, `pkt_req` stays high until an edge samples `pkt_ack` high, and it is low after that edge. While `pkt_req` is high, `pkt_byte` shows the identification byte `ADDR_BYTE` (default 0x3B).
- R4: In the clocks after the acknowledge edge, the bytes come one per clock in this order: {tag[5:0], status[1:0]}, status[9:2], status[17:10], status[25:18]. The tag is `ctrl_wd[7:2]` as held at the acknowledge edge. Outside a packet and outside a request, `pkt_byte` is 0x00.
- R5: Every payload byte comes from the status value sampled at the acknowledge edge, even when `status_in` changes while the packet is being sent.
- R6: A packet has 2 + ceil((PAYLOAD_W-2)/8) bytes (2 bytes when PAYLOAD_W is 2 or less). Status bits at or above PAYLOAD_W are sent as zeros. After the last byte, `pkt_req` is low and `pkt_byte` returns to 0x00.
- R7: In single-report mode the mode returns to off after the last byte of the packet, and later status changes raise no request.
- R8: Writing mode 11 (automatic) sends one packet. After that, a change of the status while idle causes one packet. Any number of changes during a packet cause exactly one more packet after it.
- R9: With mode 00 or the reserved value 10, no request is raised, whatever the status does.
- R10: An acknowledge that arrives while no request is pending is ignored: no bytes are sent and no request follows.
- R11: A control write made while a request is pending does not withdraw that request. The packet takes the tag that is in force at its acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ctrl_we | input | 1 | One-cycle write strobe for the control value |
| ctrl_wd | input | 8 | Control value: [1:0] mode, [7:2] sequence tag |
| status_in | input | STAT_W (26) | Status word to report |
| pkt_req | output | 1 | Request for the status channel |
| pkt_ack | input | 1 | Grant; the identification byte is taken in this cycle |
| pkt_byte | output | 8 | Byte presented to the channel |

## Verification
The assertions check the handshake on every cycle. They confirm that a request is held until it is acknowledged, that it falls after the acknowledge, and that the identification byte is shown while the request is up. They also check that the first payload byte carries the tag and the low status bits sampled at the acknowledge, that a single-report mode clears itself at the end of its packet, and that modes 00 and 10 never raise a request. Other behaviour depends on stimulus history and can only be shown by the bench scenarios. This covers snapshot consistency under mid-packet status changes, the collapse of many changes into one extra automatic packet, the packet lengths of narrower payload widths, and an acknowledge that arrives with no request pending.

// File: rtl/statpkt_pkg.sv
// Package: shared types and size helpers for the status packet generator.
// Assumes the sequence tag fills the upper six bits of an 8-bit control byte.
package statpkt_pkg;

    localparam int SEQ_W = 6;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'b00,
        MODE_ONCE = 2'b01,
        MODE_RSVD = 2'b10,
        MODE_AUTO = 2'b11
    } rpt_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_SEND
    } seq_state_e;

    // Total bytes in a packet: identification byte, first payload byte, rest.
    function automatic int pkt_bytes(input int pw);
        if (pw <= 2) return 2;
        return 2 + (pw - 2 + 7) / 8;
    endfunction

endpackage

// File: rtl/stat_ctrl_reg.sv
// Module: control register for the status packet generator.
// Holds the report mode and the sequence tag. A write strobe loads both.
// A single-report mode falls back to off when its packet ends, unless a
// write happens in that same cycle.
module stat_ctrl_reg
    import statpkt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [7:0]       wd,
    input  logic             pkt_last,
    output rpt_mode_e        mode,
    output logic [SEQ_W-1:0] seq_id
);

    // Load the control value, or clear the single-report mode at packet end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode   <= MODE_OFF;
            seq_id <= '0;
        end else if (we) begin
            mode   <= rpt_mode_e'(wd[1:0]);
            seq_id <= wd[7:2];
        end else if (pkt_last && mode == MODE_ONCE) begin
            mode   <= MODE_OFF;
        end
    end

endmodule

// File: rtl/stat_change_det.sv
// Module: change detector for automatic reporting.
// Keeps the status seen on the previous clock and raises a pending flag
// when the status differs from it. The flag is set when automatic mode is
// written, and cleared when a packet is granted (the snapshot then holds
// the latest value) or when automatic mode is left.
module stat_change_det #(
    parameter int W = 26
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] stat_in,
    input  logic         arm,
    input  logic         disarm,
    input  logic         auto_en,
    input  logic         take,
    output logic         dirty
);

    logic [W-1:0] prev_q;
    logic         changed;

    assign changed = (stat_in != prev_q);

    // Track the previous status value.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= stat_in;
    end

    // Pending-report flag: arm first, then disarm, grant, change.
    always_ff @(posedge clk) begin
        if (!rst_n)        dirty <= 1'b0;
        else if (arm)      dirty <= 1'b1;
        else if (disarm)   dirty <= 1'b0;
        else if (!auto_en) dirty <= 1'b0;
        else if (take)     dirty <= 1'b0;
        else if (changed)  dirty <= 1'b1;
    end

endmodule

// File: rtl/stat_pkt_seq.sv
// Module: packet sequencer.
// Raises a request on start and holds it until acknowledged. It captures
// the status and the tag at the acknowledge, then presents one byte per
// clock. The byte count follows PAYLOAD_W. Assumes an acknowledge is
// only meaningful while the request is high.
module stat_pkt_seq
    import statpkt_pkg::*;
#(
    parameter int         PAYLOAD_W = 26,
    parameter logic [7:0] ADDR_BYTE = 8'h3B
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 ack,
    input  logic [SEQ_W-1:0]     seq_id,
    input  logic [PAYLOAD_W-1:0] stat_in,
    output logic                 req,
    output logic [7:0]           byte_out,
    output logic                 take,
    output logic                 last
);

    localparam int NB    = pkt_bytes(PAYLOAD_W);
    localparam int IW    = $clog2(NB);
    localparam int PAD_W = 2 + 8 * (NB - 2);

    seq_state_e       state;
    logic [IW-1:0]    idx;
    logic [PAD_W-1:0] snap_in;
    logic [PAD_W-1:0] snap;
    logic [SEQ_W-1:0] seq_snap;
    logic [7:0]       frame [NB];

    // Widen the payload to whole bytes, with zeros above PAYLOAD_W.
    generate
        if (PAD_W > PAYLOAD_W) begin : g_pad
            assign snap_in = {{(PAD_W - PAYLOAD_W){1'b0}}, stat_in};
        end else begin : g_full
            assign snap_in = stat_in;
        end
    endgenerate

    assign req  = (state == ST_REQ);
    assign take = req && ack;
    assign last = (state == ST_SEND) && (idx == IW'(NB - 1));

    // Byte layout: fixed byte, tag with two low bits, then 8-bit slices.
    assign frame[0] = ADDR_BYTE;
    assign frame[1] = {seq_snap, snap[1:0]};
    generate
        for (genvar k = 2; k < NB; k++) begin : g_slice
            assign frame[k] = snap[2 + 8 * (k - 2) +: 8];
        end
    endgenerate

    // Sequencing: idle, requesting, then sending bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            idx      <= '0;
            snap     <= '0;
            seq_snap <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) state <= ST_REQ;
                end
                ST_REQ: begin
                    if (ack) begin
                        state    <= ST_SEND;
                        idx      <= IW'(1);
                        snap     <= snap_in;
                        seq_snap <= seq_id;
                    end
                end
                ST_SEND: begin
                    if (idx == IW'(NB - 1)) begin
                        state <= ST_IDLE;
                        idx   <= '0;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Output byte selection.
    always_comb begin
        unique case (state)
            ST_REQ:  byte_out = ADDR_BYTE;
            ST_SEND: byte_out = frame[idx];
            default: byte_out = 8'h00;
        endcase
    end

endmodule

// File: rtl/stat_pkt_gen.sv
// Module: top of the byte-serial status packet generator.
// Joins the control register, the change detector and the sequencer.
// Only the low PAYLOAD_W bits of the status are reported or watched.
module stat_pkt_gen
    import statpkt_pkg::*;
#(
    parameter int         STAT_W    = 26,
    parameter int         PAYLOAD_W = 26,
    parameter logic [7:0] ADDR_BYTE = 8'h3B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic [7:0]        ctrl_wd,
    input  logic [STAT_W-1:0] status_in,
    output logic              pkt_req,
    input  logic              pkt_ack,
    output logic [7:0]        pkt_byte
);

    rpt_mode_e              mode_q;
    logic [SEQ_W-1:0]       seq_q;
    logic                   dirty;
    logic                   take;
    logic                   pkt_last;
    logic                   start;
    logic                   arm;
    logic                   disarm;
    logic [PAYLOAD_W-1:0]   pay;

    assign pay    = status_in[PAYLOAD_W-1:0];
    assign arm    = ctrl_we && (ctrl_wd[1:0] == MODE_AUTO);
    assign disarm = ctrl_we && !arm;
    assign start  = (mode_q == MODE_ONCE) || ((mode_q == MODE_AUTO) && dirty);

    stat_ctrl_reg u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (ctrl_we),
        .wd       (ctrl_wd),
        .pkt_last (pkt_last),
        .mode     (mode_q),
        .seq_id   (seq_q)
    );

    stat_change_det #(.W(PAYLOAD_W)) u_chg (
        .clk     (clk),
        .rst_n   (rst_n),
        .stat_in (pay),
        .arm     (arm),
        .disarm  (disarm),
        .auto_en (mode_q == MODE_AUTO),
        .take    (take),
        .dirty   (dirty)
    );

    stat_pkt_seq #(.PAYLOAD_W(PAYLOAD_W), .ADDR_BYTE(ADDR_BYTE)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .ack      (pkt_ack),
        .seq_id   (seq_q),
        .stat_in  (pay),
        .req      (pkt_req),
        .byte_out (pkt_byte),
        .take     (take),
        .last     (pkt_last)
    );

endmodule

// File: rtl/stat_pkt_gen_chk.sv
// Module: assertion checker for stat_pkt_gen, attached by bind.
// Watches the handshake at the ports, plus the mode register and the
// end-of-packet flag inside the top.
module stat_pkt_gen_chk #(
    parameter int         STAT_W    = 26,
    parameter logic [7:0] ADDR_BYTE = 8'h3B
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ctrl_we,
    input logic [STAT_W-1:0] status_in,
    input logic              pkt_req,
    input logic              pkt_ack,
    input logic [7:0]        pkt_byte,
    input logic [1:0]        mode,
    input logic [5:0]        seq_id,
    input logic              pkt_last
);

    p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_req && !pkt_ack |=> pkt_req);

    p_req_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_req && pkt_ack |=> !pkt_req);

    p_addr_shown_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_req |-> pkt_byte == ADDR_BYTE);

    p_first_payload_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_req && pkt_ack |=> pkt_byte == {$past(seq_id), $past(status_in[1:0])});

    p_oneshot_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_last && mode == 2'b01 && !ctrl_we |=> mode == 2'b00);

    p_quiet_modes_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !pkt_req && (mode == 2'b00 || mode == 2'b10) |=> !pkt_req);

    p_end_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_last |=> !pkt_req);

endmodule

bind stat_pkt_gen stat_pkt_gen_chk #(.STAT_W(STAT_W), .ADDR_BYTE(ADDR_BYTE)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_we   (ctrl_we),
    .status_in (status_in),
    .pkt_req   (pkt_req),
    .pkt_ack   (pkt_ack),
    .pkt_byte  (pkt_byte),
    .mode      (mode_q),
    .seq_id    (seq_q),
    .pkt_last  (pkt_last)
);

// File: tb/sim_stat_pkt_gen.sv
module sim_stat_pkt_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_we = 1'b0;
    logic [7:0]  ctrl_wd = 8'h00;
    logic [25:0] status_in = '0;
    logic        pkt_ack = 1'b0;
    logic        req0, req1, req2;
    logic [7:0]  byte0, byte1, byte2;

    int checks = 0;
    int fails = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    stat_pkt_gen u0 (.clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wd(ctrl_wd),
        .status_in(status_in), .pkt_req(req0), .pkt_ack(pkt_ack), .pkt_byte(byte0));
    stat_pkt_gen #(.PAYLOAD_W(12)) u1 (.clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we),
        .ctrl_wd(ctrl_wd), .status_in(status_in), .pkt_req(req1), .pkt_ack(pkt_ack),
        .pkt_byte(byte1));
    stat_pkt_gen #(.PAYLOAD_W(2)) u2 (.clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we),
        .ctrl_wd(ctrl_wd), .status_in(status_in), .pkt_req(req2), .pkt_ack(pkt_ack),
        .pkt_byte(byte2));

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    function automatic int nbytes(input int pw);
        return (pw <= 2) ? 2 : 2 + (pw - 2 + 7) / 8;
    endfunction

    function automatic logic [7:0] exp_pkt(input logic [25:0] s, input logic [5:0] sq,
                                           input int pw, input int k);
        logic [31:0] m;
        m = {6'b0, s} & ((32'd1 << pw) - 1);
        if (k == 0) return 8'h3B;
        if (k == 1) return {sq, m[1:0]};
        return 8'(m >> (2 + 8 * (k - 2)));
    endfunction

    // Behavioural reference model for u0, advanced on each rising edge.
    int          m_st = 0;
    int          m_mode = 0;
    logic [5:0]  m_seq = '0;
    bit          m_dirty = 0;
    logic [25:0] m_prev = '0;
    logic [7:0]  m_q[$];

    always @(posedge clk) begin
        int  n_mode;
        bit  n_dirty, start, take, last, arm;
        if (!rst_n) begin
            m_st = 0; m_mode = 0; m_seq = '0; m_dirty = 0; m_prev = '0; m_q.delete();
        end else begin
            start = (m_mode == 1) || (m_mode == 3 && m_dirty);
            take  = (m_st == 1) && pkt_ack;
            last  = (m_st == 2) && (m_q.size() == 1);
            arm   = ctrl_we && ctrl_wd[1:0] == 2'b11;
            if (arm) n_dirty = 1;
            else if (ctrl_we) n_dirty = 0;
            else if (m_mode != 3) n_dirty = 0;
            else if (take) n_dirty = 0;
            else if (status_in != m_prev) n_dirty = 1;
            else n_dirty = m_dirty;
            n_mode = m_mode;
            if (ctrl_we) n_mode = int'(ctrl_wd[1:0]);
            else if (last && m_mode == 1) n_mode = 0;
            if (m_st == 0) begin
                if (start) m_st = 1;
            end else if (m_st == 1) begin
                if (take) begin
                    for (int k = 1; k < 5; k++) m_q.push_back(exp_pkt(status_in, m_seq, 26, k));
                    m_st = 2;
                end
            end else begin
                void'(m_q.pop_front());
                if (m_q.size() == 0) m_st = 0;
            end
            if (ctrl_we) m_seq = ctrl_wd[7:2];
            m_mode = n_mode;
            m_dirty = n_dirty;
            m_prev = status_in;
        end
    end

    // Per-cycle compare, packet logger and acknowledge responder.
    int         ack_wait = 2;
    int         wait_cnt = 0;
    bit         ack_force = 0;
    int         pkt_cnt = 0;
    int         cap_i = 7;
    logic [7:0] cap0 [7];
    logic [7:0] cap1 [7];
    logic [7:0] cap2 [7];

    always @(negedge clk) begin
        logic [7:0] eb;
        if (rst_n) begin
            eb = (m_st == 0) ? 8'h00 : (m_st == 1) ? 8'h3B : m_q[0];
            chk(req0 === (m_st == 1), "R3 request level", 32'(req0), 32'(m_st == 1));
            chk(byte0 === eb, "R4 R5 byte stream", 32'(byte0), 32'(eb));
        end
        if (cap_i < 7) begin
            cap0[cap_i] = byte0; cap1[cap_i] = byte1; cap2[cap_i] = byte2;
            cap_i++;
        end
        if (ack_force) begin
            pkt_ack <= 1'b1;
            ack_force = 0;
        end else if (req0 && !pkt_ack && rst_n) begin
            if (wait_cnt >= ack_wait) begin
                pkt_ack <= 1'b1;
                wait_cnt = 0;
                pkt_cnt++;
                cap0[0] = byte0; cap1[0] = byte1; cap2[0] = byte2;
                cap_i = 1;
            end else begin
                wait_cnt++;
            end
        end else begin
            pkt_ack <= 1'b0;
        end
    end

    task automatic wr_ctrl(input logic [7:0] v);
        @(negedge clk);
        ctrl_we = 1'b1;
        ctrl_wd = v;
        @(negedge clk);
        ctrl_we = 1'b0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_win(input string tag, input int which, input logic [25:0] s,
                             input logic [5:0] sq, input int pw);
        logic [7:0] got, expv;
        for (int i = 0; i < 7; i++) begin
            got  = (which == 0) ? cap0[i] : (which == 1) ? cap1[i] : cap2[i];
            expv = (i < nbytes(pw)) ? exp_pkt(s, sq, pw, i) : 8'h00;
            chk(got === expv, tag, 32'(got), 32'(expv));
        end
    endtask

    // Watchdog.
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                fails++;
                checks++;
                $display("FAIL watchdog expired");
                $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        int base;
        logic [25:0] s1;
        // R1: reset state
        settle(4);
        chk(req0 === 1'b0, "R1 request in reset", 32'(req0), 0);
        chk(byte0 === 8'h00, "R1 byte in reset", 32'(byte0), 0);
        rst_n = 1'b1;
        settle(2);
        status_in = 26'h00000F0;
        settle(2);
        status_in = 26'h3000001;
        settle(8);
        chk(pkt_cnt == 0, "R1 no report after reset", pkt_cnt, 0);
        chk(req0 === 1'b0, "R1 request stays low", 32'(req0), 0);

        // R2 / R4 / R6: single report with a known word
        status_in = 26'h1234567;
        @(negedge clk);
        ctrl_we = 1'b1; ctrl_wd = 8'hA9;
        @(negedge clk);
        ctrl_we = 1'b0;
        chk(req0 === 1'b0, "R2 request not yet up", 32'(req0), 0);
        @(negedge clk);
        chk(req0 === 1'b1, "R2 request one edge after load", 32'(req0), 1);
        settle(14);
        chk(pkt_cnt == 1, "R2 one packet", pkt_cnt, 1);
        chk(cap0[0] == 8'h3B && cap0[1] == 8'hAB && cap0[2] == 8'h59 &&
            cap0[3] == 8'hD1 && cap0[4] == 8'h48, "R4 known packet",
            {cap0[1], cap0[2], cap0[3], cap0[4]}, 32'hAB59D148);
        check_win("R6 width 26", 0, 26'h1234567, 6'h2A, 26);
        check_win("R6 width 12", 1, 26'h1234567, 6'h2A, 12);
        check_win("R6 width 2", 2, 26'h1234567, 6'h2A, 2);

        // R7: single mode has cleared itself
        status_in = 26'h0155AA3;
        settle(3);
        status_in = 26'h2000000;
        settle(10);
        chk(pkt_cnt == 1, "R7 no report after single", pkt_cnt, 1);

        // R5: status changes during the packet do not leak into it
        s1 = 26'h2C0FFEE;
        status_in = s1;
        ack_wait = 0;
        wr_ctrl(8'h45);
        wait (pkt_cnt == 2);
        @(negedge clk);
        status_in = 26'h1111111;
        @(negedge clk);
        status_in = 26'h0222222;
        settle(10);
        check_win("R5 snapshot held", 0, s1, 6'h11, 26);

        // R8: automatic mode
        base = pkt_cnt;
        wr_ctrl(8'h17);
        settle(15);
        chk(pkt_cnt == base + 1, "R8 packet on entering auto", pkt_cnt, base + 1);
        settle(5);
        status_in = 26'h0000777;
        settle(15);
        chk(pkt_cnt == base + 2, "R8 packet per idle change", pkt_cnt, base + 2);
        status_in = 26'h0000778;
        wait (pkt_cnt == base + 3);
        @(negedge clk);
        status_in = 26'h0000779;
        @(negedge clk);
        status_in = 26'h000077A;
        @(negedge clk);
        status_in = 26'h000077B;
        settle(25);
        chk(pkt_cnt == base + 4, "R8 changes in packet give one more", pkt_cnt, base + 4);
        check_win("R8 latest status sent", 0, 26'h000077B, 6'h05, 26);

        // R9: off and reserved modes stay quiet
        wr_ctrl(8'h02);
        base = pkt_cnt;
        for (int i = 0; i < 6; i++) begin
            status_in = status_in + 26'h0101;
            settle(3);
        end
        wr_ctrl(8'h00);
        status_in = 26'h3ABCDEF;
        settle(10);
        chk(pkt_cnt == base, "R9 quiet modes", pkt_cnt, base);

        // R10: stray acknowledge while idle
        @(negedge clk);
        ack_force = 1;
        settle(3);
        chk(req0 === 1'b0, "R10 no request after stray ack", 32'(req0), 0);
        chk(byte0 === 8'h00, "R10 no bytes after stray ack", 32'(byte0), 0);
        chk(pkt_cnt == base, "R10 no packet", pkt_cnt, base);

        // R11: control write during a pending request
        ack_wait = 8;
        wr_ctrl(8'h17);
        settle(3);
        wr_ctrl(8'hFC);
        chk(req0 === 1'b1, "R11 request kept after write", 32'(req0), 1);
        settle(20);
        chk(pkt_cnt == base + 1, "R11 packet completed", pkt_cnt, base + 1);
        chk(cap0[1][7:2] == 6'h3F, "R11 tag at acknowledge", 32'(cap0[1][7:2]), 32'h3F);
        status_in = 26'h0000001;
        settle(10);
        chk(pkt_cnt == base + 1, "R11 off after write", pkt_cnt, base + 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule